// File: doc/BRIEF.md
# Network Terminal Latency and Throughput Meter

This block sits passively beside the delivery port of a network-on-chip terminal. It watches the flit stream that the router hands to the local node. A flit counts only on a cycle where valid and ready are both high. The meter tracks where packets start and end from the end-of-packet marker. From every packet it gathers a required-bandwidth value carried in the header flit and a creation timestamp carried in the trailer flit. The latency of each packet is the global cycle count at the moment its trailer is accepted, minus that timestamp.

Running statistics are kept in hardware and updated in the cycle each packet completes. These are the smallest, largest and summed latency, the number of packets and flits, and the summed bandwidth. Every packet on the terminal is included, and there is no per-flow filter. When a run ends, a collector pulses a capture strobe. This copies the statistics into a snapshot register. The collector then clocks the snapshot out one bit per shift-enable cycle. The serial input of each meter takes the serial output of its upstream neighbour, so any number of meters share one readout chain.

Top module: `noc_traffic_meter`

## Requirements
- R1: After synchronous reset the packet, flit, latency-sum and bandwidth-sum totals are zero, the minimum latency is all ones (255) and the maximum latency is zero.
- R2: The flit total rises by one on each cycle with both flit_valid and flit_ready high, and on no other cycle.
- R3: A packet is counted only when a flit with flit_eop high is accepted. The next accepted flit after that, or the first flit after reset, is the header of the next packet. A one-flit packet is both header and trailer.
- R4: Packet latency is glob_cycle minus the trailer's bits [31:0], taken modulo 2^32 in the cycle the trailer is accepted. The latency sum adds every such latency.
- R5: The minimum latency is an 8-bit register. It takes the smaller of its value and the packet latency, and a latency of 255 or more counts as 255.
- R6: The maximum latency is a 16-bit register. It takes the larger of its value and the packet latency, and a latency of 65535 or more counts as 65535.
- R7: The bandwidth sum adds header bits [6:0] of every completed packet.
- R8: A cycle with capture high loads the snapshot, MSB to LSB: packet total (28 bits), flit total (32), latency sum (32), minimum (8), maximum (16), bandwidth sum (32). This is 148 bits in all. Capture has priority over shift_en.
- R9: Each shift_en cycle without capture moves the snapshot one place toward its MSB. shift_in enters at the LSB, and shift_out always shows the MSB, so a second full shift pass returns the bits that were fed in.
- R10: Capturing and shifting leave the running statistics unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | Router presents a flit |
| flit_ready | input | 1 | Node accepts the flit |
| flit_data | input | 32 | Flit payload |
| flit_eop | input | 1 | Marks the last flit of a packet |
| glob_cycle | input | 32 | Global experiment cycle counter |
| capture | input | 1 | Load statistics into the snapshot |
| shift_en | input | 1 | Advance the readout chain one bit |
| shift_in | input | 1 | Serial input from the upstream meter |
| shift_out | output | 1 | Serial output, snapshot MSB |

## Verification
The bench pairs every flit with stall cycles where only valid or only ready is high and the end marker is set. A meter that counts without a full handshake would report too many flits or packets. One-flit packets test that the header bandwidth and the trailer timestamp come from the same flit. A timestamp larger than the current cycle tests wrap-around subtraction. Latencies of 1000 and 70000 after a fresh reset push the minimum and maximum into saturation, which a design that truncates instead of clipping would get wrong. A second shift pass with a known fill pattern shows whether the chain loses, reverses or misplaces bits.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic {TM_AT_HEAD = 1'b0, TM_IN_BODY = 1'b1} tm_pos_e;
endpackage

// File: rtl/tm_pkt_tracker.sv
module tm_pkt_tracker
  import tm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 32,
  parameter int BW_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flit_valid,
  input  logic              flit_ready,
  input  logic [DATA_W-1:0] flit_data,
  input  logic              flit_eop,
  input  logic [CYC_W-1:0]  glob_cycle,
  output logic              flit_acc,
  output logic              pkt_done,
  output logic [CYC_W-1:0]  pkt_lat,
  output logic [BW_W-1:0]   pkt_bw
);
  tm_pos_e          pos_q;
  logic [BW_W-1:0]  bw_q;
  logic             unused_data;

  assign unused_data = ^flit_data;
  assign flit_acc    = flit_valid && flit_ready;
  assign pkt_done    = flit_acc && flit_eop;
  // header bandwidth: live from the flit when it is the header, else held
  assign pkt_bw      = (pos_q == TM_AT_HEAD) ? flit_data[BW_W-1:0] : bw_q;
  assign pkt_lat     = glob_cycle - flit_data[CYC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= TM_AT_HEAD;
      bw_q  <= '0;
    end else if (flit_acc) begin
      if (pos_q == TM_AT_HEAD) bw_q <= flit_data[BW_W-1:0];
      pos_q <= flit_eop ? TM_AT_HEAD : TM_IN_BODY;
    end
  end

  assert_head_after_eop_R3: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> (pos_q == TM_AT_HEAD));
endmodule

// File: rtl/tm_stats.sv
module tm_stats #(
  parameter int CYC_W      = 32,
  parameter int BW_W       = 7,
  parameter int BW_ACC_W   = 32,
  parameter int FLIT_ACC_W = 32,
  parameter int PKT_ACC_W  = 28,
  parameter int LAT_ACC_W  = 32,
  parameter int MIN_W      = 8,
  parameter int MAX_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flit_acc,
  input  logic                  pkt_done,
  input  logic [CYC_W-1:0]      pkt_lat,
  input  logic [BW_W-1:0]       pkt_bw,
  output logic [PKT_ACC_W-1:0]  pkt_cnt,
  output logic [FLIT_ACC_W-1:0] flit_cnt,
  output logic [LAT_ACC_W-1:0]  lat_sum,
  output logic [MIN_W-1:0]      lat_min,
  output logic [MAX_W-1:0]      lat_max,
  output logic [BW_ACC_W-1:0]   bw_sum
);
  logic [MIN_W-1:0] lat_clip_min;
  logic [MAX_W-1:0] lat_clip_max;

  // saturate the packet latency into each register's range
  assign lat_clip_min = (|pkt_lat[CYC_W-1:MIN_W]) ? {MIN_W{1'b1}} : pkt_lat[MIN_W-1:0];
  assign lat_clip_max = (|pkt_lat[CYC_W-1:MAX_W]) ? {MAX_W{1'b1}} : pkt_lat[MAX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_cnt  <= '0;
      flit_cnt <= '0;
      lat_sum  <= '0;
      lat_min  <= '1;
      lat_max  <= '0;
      bw_sum   <= '0;
    end else begin
      if (flit_acc) flit_cnt <= flit_cnt + 1'b1;
      if (pkt_done) begin
        pkt_cnt <= pkt_cnt + 1'b1;
        lat_sum <= lat_sum + LAT_ACC_W'(pkt_lat);
        bw_sum  <= bw_sum + BW_ACC_W'(pkt_bw);
        if (lat_clip_min < lat_min) lat_min <= lat_clip_min;
        if (lat_clip_max > lat_max) lat_max <= lat_clip_max;
      end
    end
  end

  assert_flit_step_R2: assert property (@(posedge clk) disable iff (rst)
    flit_acc |=> (flit_cnt == $past(flit_cnt) + 1'b1));
  assert_flit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !flit_acc |=> $stable(flit_cnt));
  assert_pkt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !pkt_done |=> ($stable(pkt_cnt) && $stable(lat_sum) && $stable(bw_sum)));
  assert_min_no_rise_R5: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> (lat_min <= $past(lat_min)));
  assert_max_no_fall_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> (lat_max >= $past(lat_max)));
  assert_min_le_max_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_cnt != '0) |-> (MAX_W'(lat_min) <= lat_max));
endmodule

// File: rtl/tm_shift_chain.sv
module tm_shift_chain #(
  parameter int SNAP_W = 148
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SNAP_W-1:0] snap,
  input  logic              capture,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic              shift_out
);
  logic [SNAP_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)           sreg_q <= '0;
    else if (capture)  sreg_q <= snap;
    else if (shift_en) sreg_q <= {sreg_q[SNAP_W-2:0], shift_in};
  end

  assign shift_out = sreg_q[SNAP_W-1];

  assert_capture_load_R8: assert property (@(posedge clk) disable iff (rst)
    capture |=> (sreg_q == $past(snap)));
  assert_shift_lsb_R9: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !capture) |=> (sreg_q[0] == $past(shift_in)));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !capture) |=> $stable(sreg_q));
endmodule

// File: rtl/noc_traffic_meter.sv
module noc_traffic_meter #(
  parameter int DATA_W     = 32,
  parameter int CYC_W      = 32,
  parameter int BW_W       = 7,
  parameter int BW_ACC_W   = 32,
  parameter int FLIT_ACC_W = 32,
  parameter int PKT_ACC_W  = 28,
  parameter int LAT_ACC_W  = 32,
  parameter int MIN_W      = 8,
  parameter int MAX_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flit_valid,
  input  logic              flit_ready,
  input  logic [DATA_W-1:0] flit_data,
  input  logic              flit_eop,
  input  logic [CYC_W-1:0]  glob_cycle,
  input  logic              capture,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic              shift_out
);
  localparam int SNAP_W = PKT_ACC_W + FLIT_ACC_W + LAT_ACC_W + MIN_W + MAX_W + BW_ACC_W;

  logic                  flit_acc, pkt_done;
  logic [CYC_W-1:0]      pkt_lat;
  logic [BW_W-1:0]       pkt_bw;
  logic [PKT_ACC_W-1:0]  pkt_cnt;
  logic [FLIT_ACC_W-1:0] flit_cnt;
  logic [LAT_ACC_W-1:0]  lat_sum;
  logic [MIN_W-1:0]      lat_min;
  logic [MAX_W-1:0]      lat_max;
  logic [BW_ACC_W-1:0]   bw_sum;
  logic [SNAP_W-1:0]     snap;

  tm_pkt_tracker #(.DATA_W(DATA_W), .CYC_W(CYC_W), .BW_W(BW_W)) trk_i (
    .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_eop(flit_eop), .glob_cycle(glob_cycle),
    .flit_acc(flit_acc), .pkt_done(pkt_done), .pkt_lat(pkt_lat), .pkt_bw(pkt_bw)
  );

  tm_stats #(
    .CYC_W(CYC_W), .BW_W(BW_W), .BW_ACC_W(BW_ACC_W), .FLIT_ACC_W(FLIT_ACC_W),
    .PKT_ACC_W(PKT_ACC_W), .LAT_ACC_W(LAT_ACC_W), .MIN_W(MIN_W), .MAX_W(MAX_W)
  ) st_i (
    .clk(clk), .rst(rst), .flit_acc(flit_acc), .pkt_done(pkt_done),
    .pkt_lat(pkt_lat), .pkt_bw(pkt_bw), .pkt_cnt(pkt_cnt), .flit_cnt(flit_cnt),
    .lat_sum(lat_sum), .lat_min(lat_min), .lat_max(lat_max), .bw_sum(bw_sum)
  );

  // readout order is part of the collector's contract (R8)
  assign snap = {pkt_cnt, flit_cnt, lat_sum, lat_min, lat_max, bw_sum};

  tm_shift_chain #(.SNAP_W(SNAP_W)) sc_i (
    .clk(clk), .rst(rst), .snap(snap), .capture(capture), .shift_en(shift_en),
    .shift_in(shift_in), .shift_out(shift_out)
  );

  assert_stats_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (!flit_acc && (capture || shift_en)) |=> ($stable(pkt_cnt) && $stable(flit_cnt)));
endmodule

// File: tb/noc_traffic_meter_tb_top.sv
module noc_traffic_meter_tb_top;
  localparam int SNAP_W = 148;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flit_valid = 1'b0, flit_ready = 1'b0, flit_eop = 1'b0;
  logic [31:0] flit_data = '0, glob_cycle = '0;
  logic        capture = 1'b0, shift_en = 1'b0, shift_in = 1'b0;
  logic        shift_out;

  int errors = 0, checks = 0, cyc = 0;

  logic [27:0] e_pkt;
  logic [31:0] e_flit, e_lat, e_bw;
  logic [7:0]  e_min;
  logic [15:0] e_max;
  logic [6:0]  e_hbw;
  logic        e_head;
  logic [SNAP_W-1:0] exp_q[$];
  logic [SNAP_W-1:0] fill_q[$];

  always #10 clk = ~clk;

  noc_traffic_meter dut_i (
    .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_eop(flit_eop), .glob_cycle(glob_cycle),
    .capture(capture), .shift_en(shift_en), .shift_in(shift_in), .shift_out(shift_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected under 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_reset();
    e_pkt = '0; e_flit = '0; e_lat = '0; e_bw = '0;
    e_min = 8'hFF; e_max = '0; e_hbw = '0; e_head = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one flit with a valid-only stall and a ready-only stall before it (R2, R3)
  task automatic put_flit(input logic [31:0] d, input logic eop);
    logic [31:0] lat;
    flit_data = d; flit_eop = eop;
    flit_valid = 1'b1; flit_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    flit_valid = 1'b0; flit_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    flit_valid = 1'b1; flit_ready = 1'b1;
    @(posedge clk);
    e_flit = e_flit + 1;
    if (e_head) e_hbw = d[6:0];
    if (eop) begin
      lat   = glob_cycle - d;
      e_pkt = e_pkt + 1;
      e_lat = e_lat + lat;
      e_bw  = e_bw + 32'(e_hbw);
      if (((lat > 255) ? 8'hFF : lat[7:0]) < e_min) e_min = (lat > 255) ? 8'hFF : lat[7:0];
      if (((lat > 65535) ? 16'hFFFF : lat[15:0]) > e_max) e_max = (lat > 65535) ? 16'hFFFF : lat[15:0];
    end
    e_head = eop;
    @(negedge clk);
    flit_valid = 1'b0; flit_ready = 1'b0; flit_eop = 1'b0;
  endtask

  task automatic send_pkt(input int len, input logic [6:0] bw, input logic [31:0] ts,
                          input logic [31:0] now);
    glob_cycle = now;
    for (int i = 0; i < len; i++) begin
      if (i == len - 1)  put_flit(ts, 1'b1);
      else if (i == 0)   put_flit({25'h1ABC, bw}, 1'b0);
      else               put_flit(32'hDEAD0000 + i, 1'b0);
    end
    if (len == 1) e_hbw = e_hbw; // header and trailer share the flit
  endtask

  // driver side: capture and push expected snapshot; monitor side: shift out and compare
  task automatic readout(input logic [SNAP_W-1:0] fill);
    logic [SNAP_W-1:0] got, exp;
    exp_q.push_back({e_pkt, e_flit, e_lat, e_min, e_max, e_bw});
    fill_q.push_back(fill);
    capture = 1'b1;
    @(posedge clk); @(negedge clk);
    capture = 1'b0;
    got = '0;
    for (int i = 0; i < SNAP_W; i++) begin
      got = {got[SNAP_W-2:0], shift_out};
      shift_en = 1'b1;
      shift_in = fill[SNAP_W-1-i];
      @(posedge clk); @(negedge clk);
    end
    shift_en = 1'b0;
    exp = exp_q.pop_front();
    chk("R8 R3 packet total", 32'(got[147:120]), 32'(exp[147:120]));
    chk("R8 R2 flit total",   got[119:88], exp[119:88]);
    chk("R8 R4 latency sum",  got[87:56],  exp[87:56]);
    chk("R8 R5 minimum",      32'(got[55:48]), 32'(exp[55:48]));
    chk("R8 R6 maximum",      32'(got[47:32]), 32'(exp[47:32]));
    chk("R8 R7 bandwidth sum", got[31:0],  exp[31:0]);
  endtask

  // second pass without capture returns the fill bits (R9)
  task automatic chain_pass();
    logic [SNAP_W-1:0] got, exp;
    got = '0;
    for (int i = 0; i < SNAP_W; i++) begin
      got = {got[SNAP_W-2:0], shift_out};
      shift_en = 1'b1; shift_in = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    shift_en = 1'b0;
    exp = fill_q.pop_front();
    chk("R9 chain high", got[147:116], exp[147:116]);
    chk("R9 chain low",  got[31:0],    exp[31:0]);
    chk("R9 chain mid",  got[79:48],   exp[79:48]);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R1: reset values
    readout({37{4'hA}});
    chain_pass();
    fill_q.delete();
    // R4, R7, R2: three-flit packet, latency 50
    send_pkt(3, 7'd10, 32'd100, 32'd150);
    // R3: one-flit packet, header and trailer are the same flit, latency 3
    send_pkt(1, 7'd0, 32'd1000, 32'd1003);
    readout({148{1'b0}});
    fill_q.delete();
    // R10: readout did not disturb totals; R6 larger latency 300, R4 wrap
    send_pkt(2, 7'd100, 32'd0, 32'd300);
    send_pkt(4, 7'd1, 32'hFFFF_FFF0, 32'h0000_0010);
    readout({4'h5, {36{4'hC}}});
    chain_pass();
    // R5/R6 saturation from a fresh start
    do_reset();
    send_pkt(2, 7'd127, 32'd5, 32'd1005);
    readout({148{1'b1}});
    fill_q.delete();
    send_pkt(1, 7'd3, 32'd10, 32'd70010);
    readout({74{2'b10}});
    chain_pass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule